// File: doc/BRIEF.md
# Video Timing Mode Matcher

This block classifies an incoming video signal by comparing three measured durations against a fixed list of standard modes. The three durations are the vertical period (one frame, or one field for interlaced signals), the line period and the horizontal sync pulse width. Each is a count of cycles of a 27 MHz reference clock. A measurement front end loads the three counts and pulses a strobe. The matcher then scans its mode list one entry per clock and reports the first entry whose three windows all contain the measured values. If no entry fits, it reports a miss. If no input is detected, it reports a missing link without scanning.

Every acceptance window is computed at elaboration from the mode's pixel clock, total width, total lines, sync width and interlace flag. The hardware therefore holds only comparators and constant bounds. Because the block matches within tolerance windows, two modes with nearby rates can both fit a measurement. In that case the order of the list decides which one is reported.

Top module: `vtm_matcher`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, `done`, `match`, `nomatch` and `nolink` are 0 and `mode_idx` is 0.
- R2: The mode list, by index, is given as (pixel clock Hz, total width, total lines, sync pixels, interlaced):
  - 0 = (25175000, 800, 525, 96, no)
  - 1 = (27000000, 858, 525, 62, no)
  - 2 = (74250000, 1650, 750, 40, no)
  - 3 = (74250000, 2200, 1125, 44, yes)
  - 4 = (148500000, 2200, 1125, 44, no)
  - 5 = (74250000, 2200, 1125, 44, no)
  - 6 = (74175824, 2200, 1125, 44, no)
- R3: With L = floor(pixel clock / total width), the line period fits when it lies between floor(26730000/L) and floor(27270000/L), both bounds inclusive.
- R4: The vertical period fits when it lies between floor(26811000/L)·N and floor(27189000/L)·N, both bounds inclusive. N is the number of lines.
- R5: For an interlaced mode, N is floor(total lines / 2), since a single field is measured. For a progressive mode, N is the total lines.
- R6: The sync width fits when it lies within ±2 of S = floor(27000·sync pixels / floor(pixel clock/1000)), both bounds inclusive.
- R7: A mode is reported only when all three windows fit. When several modes fit, the lowest index is reported with `match`=1.
- R8: When no mode fits, `done` pulses with `nomatch`=1, `match`=0 and `mode_idx`=0.
- R9: A strobe while `link_up` is 0 aborts any scan in progress. One cycle later, `done` pulses with `nolink`=1, and no other outcome follows for that strobe.
- R10: For a strobe sampled at a clock edge, `done` appears i+1 edges later for a hit at entry i, or 7 edges later for a miss. `done` lasts one cycle. The outcome flags and `mode_idx` hold until the next strobe.
- R11: A strobe with `link_up`=1 during a scan discards that scan. It restarts from entry 0 with the new values, and no `done` is given for the abandoned scan.
- R12: Whenever `done` is 1, exactly one of `match`, `nomatch` and `nolink` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe: new measurement present |
| link_up | input | 1 | An input signal is detected |
| frame_cnt | input | FRAME_W (22) | Vertical period in reference cycles |
| line_cnt | input | LINE_W (12) | Line period in reference cycles |
| sync_cnt | input | SYNC_W (10) | Horizontal sync width in reference cycles |
| done | output | 1 | Result pulse |
| match | output | 1 | A mode was found |
| nomatch | output | 1 | No mode fits |
| nolink | output | 1 | Search refused, no input |
| mode_idx | output | IDX_W (3) | Index of the matched mode |

## Verification
The first pair of patterns shares one line rate and one frame rate across modes 0 and 1, and differs only in sync width. It shows that the sync window alone separates those two modes. The field-length pattern at a 1080-line geometry must land on the interlaced entry rather than the progressive entry. A frame period that sits inside both the exact-rate and the 1/1.001-rate windows separates list priority from closeness. A period just above the exact-rate window shows that the slower entry is still reached. Single-count steps across every bound of the frame, line and sync windows confirm that each bound is inclusive and no wider. The restart, abort and hold sequences tell a clean restart apart from a stale result.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

  localparam int unsigned TABLE_SIZE = 7;
  localparam longint     REF_KHZ    = 27000;

  typedef struct packed {
    logic [31:0] fmin;
    logic [31:0] fmax;
    logic [15:0] lmin;
    logic [15:0] lmax;
    logic [15:0] smin;
    logic [15:0] smax;
  } vtm_win_t;

  typedef enum logic [0:0] {ST_IDLE, ST_SCAN} vtm_state_e;

  // Derives the acceptance windows of one list entry from its nominal timing.
  function automatic vtm_win_t vtm_window(input int unsigned sel);
    longint   pclk, htot, vtot, hsw, lrate, lines, hs;
    logic     ilace;
    vtm_win_t w;
    case (sel)
      1:       begin pclk = 27000000;  htot = 858;  vtot = 525;  hsw = 62; ilace = 1'b0; end
      2:       begin pclk = 74250000;  htot = 1650; vtot = 750;  hsw = 40; ilace = 1'b0; end
      3:       begin pclk = 74250000;  htot = 2200; vtot = 1125; hsw = 44; ilace = 1'b1; end
      4:       begin pclk = 148500000; htot = 2200; vtot = 1125; hsw = 44; ilace = 1'b0; end
      5:       begin pclk = 74250000;  htot = 2200; vtot = 1125; hsw = 44; ilace = 1'b0; end
      6:       begin pclk = 74175824;  htot = 2200; vtot = 1125; hsw = 44; ilace = 1'b0; end
      default: begin pclk = 25175000;  htot = 800;  vtot = 525;  hsw = 96; ilace = 1'b0; end
    endcase
    lrate  = pclk / htot;
    lines  = ilace ? vtot / 2 : vtot;
    hs     = (REF_KHZ * hsw) / (pclk / 1000);
    w.fmin = 32'(((REF_KHZ * 993) / lrate) * lines);
    w.fmax = 32'(((REF_KHZ * 1007) / lrate) * lines);
    w.lmin = 16'((REF_KHZ * 990) / lrate);
    w.lmax = 16'((REF_KHZ * 1010) / lrate);
    w.smin = 16'(hs - 2);
    w.smax = 16'(hs + 2);
    return w;
  endfunction

endpackage

// File: rtl/vtm_mode_rom.sv
module vtm_mode_rom
  import vtm_pkg::*;
#(
  parameter int NUM_MODES = 7,
  parameter int IDX_W     = 3
) (
  input  logic [IDX_W-1:0] sel,
  output vtm_win_t         win
);

  vtm_win_t tab [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_entry
    localparam vtm_win_t ENTRY = vtm_window(g);
    assign tab[g] = ENTRY;
  end

  always_comb begin
    win = tab[0];
    for (int i = 1; i < NUM_MODES; i++) begin
      if (sel == IDX_W'(i)) win = tab[i];
    end
  end

endmodule

// File: rtl/vtm_window_cmp.sv
module vtm_window_cmp
  import vtm_pkg::*;
#(
  parameter int FRAME_W = 22,
  parameter int LINE_W  = 12,
  parameter int SYNC_W  = 10
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [LINE_W-1:0]  line,
  input  logic [SYNC_W-1:0]  sync,
  input  vtm_win_t           win,
  output logic               hit
);

  logic f_ok, l_ok, s_ok;

  always_comb begin
    f_ok = (32'(frame) >= win.fmin) && (32'(frame) <= win.fmax);
    l_ok = (16'(line)  >= win.lmin) && (16'(line)  <= win.lmax);
    s_ok = (16'(sync)  >= win.smin) && (16'(sync)  <= win.smax);
    hit  = f_ok && l_ok && s_ok;
  end

endmodule

// File: rtl/vtm_scan_ctrl.sv
module vtm_scan_ctrl
  import vtm_pkg::*;
#(
  parameter int NUM_MODES = 7,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             link_up,
  input  logic             hit,
  output logic [IDX_W-1:0] scan_idx,
  output logic             load,
  output logic             done,
  output logic             match,
  output logic             nomatch,
  output logic             nolink,
  output logic [IDX_W-1:0] mode_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_MODES - 1);

  vtm_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, res_idx_d;
  logic             done_d, match_d, nomatch_d, nolink_d;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    load      = 1'b0;
    done_d    = 1'b0;
    match_d   = match;
    nomatch_d = nomatch;
    nolink_d  = nolink;
    res_idx_d = mode_idx;
    if (start) begin
      match_d   = 1'b0;
      nomatch_d = 1'b0;
      res_idx_d = '0;
      idx_d     = '0;
      if (link_up) begin
        state_d  = ST_SCAN;
        load     = 1'b1;
        nolink_d = 1'b0;
      end else begin
        state_d  = ST_IDLE;
        done_d   = 1'b1;
        nolink_d = 1'b1;
      end
    end else if (state_q == ST_SCAN) begin
      if (hit) begin
        state_d   = ST_IDLE;
        done_d    = 1'b1;
        match_d   = 1'b1;
        res_idx_d = idx_q;
      end else if (idx_q == LAST) begin
        state_d   = ST_IDLE;
        done_d    = 1'b1;
        nomatch_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      done     <= 1'b0;
      match    <= 1'b0;
      nomatch  <= 1'b0;
      nolink   <= 1'b0;
      mode_idx <= '0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      done     <= done_d;
      match    <= match_d;
      nomatch  <= nomatch_d;
      nolink   <= nolink_d;
      mode_idx <= res_idx_d;
    end
  end

  assign scan_idx = idx_q;

  // R12: a result pulse carries exactly one outcome
  p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({match, nomatch, nolink}) == 1));

  // R9: refused search answers on the next cycle
  p_nolink_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !link_up) |=> (done && nolink));

  // R11: an accepted strobe never yields a result on the following cycle
  p_restart_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && link_up) |=> !done);

  // R10: a failing entry that is not the last steps to the next one silently
  p_scan_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && !start && !hit && idx_q != LAST)
      |=> (!done && idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/vtm_matcher.sv
module vtm_matcher
  import vtm_pkg::*;
#(
  parameter  int FRAME_W   = 22,
  parameter  int LINE_W    = 12,
  parameter  int SYNC_W    = 10,
  parameter  int NUM_MODES = 7,
  localparam int IDX_W     = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               meas_valid,
  input  logic               link_up,
  input  logic [FRAME_W-1:0] frame_cnt,
  input  logic [LINE_W-1:0]  line_cnt,
  input  logic [SYNC_W-1:0]  sync_cnt,
  output logic               done,
  output logic               match,
  output logic               nomatch,
  output logic               nolink,
  output logic [IDX_W-1:0]   mode_idx
);

  logic [FRAME_W-1:0] frame_q;
  logic [LINE_W-1:0]  line_q;
  logic [SYNC_W-1:0]  sync_q;
  logic [IDX_W-1:0]   scan_idx;
  logic               load, hit;
  vtm_win_t           win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      line_q  <= '0;
      sync_q  <= '0;
    end else if (load) begin
      frame_q <= frame_cnt;
      line_q  <= line_cnt;
      sync_q  <= sync_cnt;
    end
  end

  vtm_mode_rom #(.NUM_MODES(NUM_MODES), .IDX_W(IDX_W)) u_rom (
    .sel (scan_idx),
    .win (win)
  );

  vtm_window_cmp #(.FRAME_W(FRAME_W), .LINE_W(LINE_W), .SYNC_W(SYNC_W)) u_cmp (
    .frame (frame_q),
    .line  (line_q),
    .sync  (sync_q),
    .win   (win),
    .hit   (hit)
  );

  vtm_scan_ctrl #(.NUM_MODES(NUM_MODES), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (meas_valid),
    .link_up  (link_up),
    .hit      (hit),
    .scan_idx (scan_idx),
    .load     (load),
    .done     (done),
    .match    (match),
    .nomatch  (nomatch),
    .nolink   (nolink),
    .mode_idx (mode_idx)
  );

  // R2: a reported index always names a list entry
  p_idx_in_list_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (32'(mode_idx) < 32'(NUM_MODES)));

  // R8: a miss never carries an index
  p_miss_zero_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nomatch |-> (mode_idx == '0));

endmodule

// File: tb/vtm_matcher_bench.sv
module vtm_matcher_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        meas_valid = 1'b0;
  logic        link_up = 1'b0;
  logic [21:0] frame_cnt = '0;
  logic [11:0] line_cnt = '0;
  logic [9:0]  sync_cnt = '0;
  logic        done, match, nomatch, nolink;
  logic [2:0]  mode_idx;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  vtm_matcher u_vtm_matcher (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .link_up(link_up),
    .frame_cnt(frame_cnt), .line_cnt(line_cnt), .sync_cnt(sync_cnt),
    .done(done), .match(match), .nomatch(nomatch), .nolink(nolink),
    .mode_idx(mode_idx)
  );

  typedef struct packed {
    logic [21:0] fr;
    logic [11:0] ln;
    logic [9:0]  sy;
    logic        m;
    logic [2:0]  idx;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{22'd450450, 12'd858, 10'd103, 1'b1, 3'd0, 8'd6},  // R6 sync picks mode 0
    '{22'd450450, 12'd858, 10'd62,  1'b1, 3'd1, 8'd6},  // R6 sync picks mode 1
    '{22'd450450, 12'd858, 10'd80,  1'b0, 3'd0, 8'd8},  // R8 sync fits neither
    '{22'd450000, 12'd600, 10'd15,  1'b1, 3'd2, 8'd7},  // R7
    '{22'd450000, 12'd800, 10'd16,  1'b1, 3'd3, 8'd5},  // R5 field length
    '{22'd450000, 12'd400, 10'd8,   1'b1, 3'd4, 8'd7},  // R7
    '{22'd900000, 12'd800, 10'd16,  1'b1, 3'd5, 8'd7},  // R7 fits 5 and 6
    '{22'd906000, 12'd800, 10'd16,  1'b1, 3'd6, 8'd4},  // R4 above 5, inside 6
    '{22'd446250, 12'd600, 10'd15,  1'b1, 3'd2, 8'd4},  // R4 lower bound
    '{22'd446249, 12'd600, 10'd15,  1'b0, 3'd0, 8'd4},  // R4
    '{22'd453000, 12'd600, 10'd15,  1'b1, 3'd2, 8'd4},  // R4 upper bound
    '{22'd453001, 12'd600, 10'd15,  1'b0, 3'd0, 8'd4},  // R4
    '{22'd450000, 12'd396, 10'd8,   1'b1, 3'd4, 8'd3},  // R3 lower bound
    '{22'd450000, 12'd395, 10'd8,   1'b0, 3'd0, 8'd3},  // R3
    '{22'd450000, 12'd404, 10'd8,   1'b1, 3'd4, 8'd3},  // R3 upper bound
    '{22'd450000, 12'd405, 10'd8,   1'b0, 3'd0, 8'd3},  // R3
    '{22'd450000, 12'd600, 10'd12,  1'b1, 3'd2, 8'd6},  // R6 lower bound
    '{22'd450000, 12'd600, 10'd11,  1'b0, 3'd0, 8'd6},  // R6
    '{22'd450000, 12'd600, 10'd16,  1'b1, 3'd2, 8'd6},  // R6 upper bound
    '{22'd450000, 12'd600, 10'd17,  1'b0, 3'd0, 8'd6}   // R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [21:0] fr, input logic [11:0] ln,
                        input logic [9:0] sy, input logic lk);
    @(negedge clk);
    frame_cnt = fr; line_cnt = ln; sync_cnt = sy; link_up = lk; meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    string tag;
    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    check({done, match, nomatch, nolink, mode_idx} == '0, "R1", int'({done, match, nomatch, nolink}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({done, match, nomatch, nolink, mode_idx} == '0, "R1", int'({done, match, nomatch, nolink}), 0);

    for (int v = 0; v < NV; v++) begin
      tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
      strobe(VEC[v].fr, VEC[v].ln, VEC[v].sy, 1'b1);
      wait_done(lat);
      check(match == VEC[v].m && nomatch == !VEC[v].m && !nolink, tag, int'(match), int'(VEC[v].m));
      check(mode_idx == VEC[v].idx, tag, int'(mode_idx), int'(VEC[v].idx));
      // R10 latency from the sampling edge
      check(lat == (VEC[v].m ? int'(VEC[v].idx) + 2 : 8), "R10 latency", lat, VEC[v].m ? int'(VEC[v].idx) + 2 : 8);
    end

    // R10: done lasts one cycle, outcome holds
    strobe(22'd450000, 12'd400, 10'd8, 1'b1);
    wait_done(lat);
    repeat (3) @(negedge clk);
    check(!done && match && mode_idx == 3'd4, "R10 hold", int'({done, match}), 1);

    // R11: restart during a scan
    strobe(22'd450450, 12'd858, 10'd80, 1'b1);
    @(negedge clk);
    check(!done, "R11 no early done", int'(done), 0);
    strobe(22'd450450, 12'd858, 10'd103, 1'b1);
    wait_done(lat);
    check(lat == 2 && match && mode_idx == 3'd0, "R11 restart", lat, 2);
    repeat (10) @(negedge clk);
    check(!done && match && !nomatch, "R11 stale scan", int'(nomatch), 0);

    // R9: strobe without link aborts a running scan
    strobe(22'd450450, 12'd858, 10'd80, 1'b1);
    strobe(22'd450450, 12'd858, 10'd80, 1'b0);
    check(done && nolink && !match && !nomatch, "R9 nolink", int'({done, nolink}), 3);
    lat = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check(lat == 0 && nolink && !nomatch, "R9 aborted", lat, 0);

    // R12 / R9: a refused search with no prior scan
    strobe(22'd450000, 12'd600, 10'd15, 1'b0);
    check(done && nolink && mode_idx == 3'd0, "R12 single outcome", int'({match, nomatch, nolink}), 1);
    // R1 relaunch after refusal clears the flag
    strobe(22'd450000, 12'd600, 10'd15, 1'b1);
    check(!nolink && !done, "R11 relaunch", int'(nolink), 0);
    wait_done(lat);
    check(match && mode_idx == 3'd2, "R7 after refusal", int'(mode_idx), 2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule